// File: doc/BRIEF.md
# Control-Flow Redirect Resolver

This combinational unit decides, for one 32-bit instruction, whether the fetch stream must leave its sequential path. It receives the current program counter, the instruction word and the two source register values. It returns a redirect flag, the next fetch address, the return-address value for jumps with its write enable, a flag for a redirect target that is not 4-byte aligned, and a flag for a malformed conditional branch.

Three instruction classes are resolved here:
- The conditional branch (major opcode 0x63). The comparison is selected by funct3 and may be signed or unsigned.
- The PC-relative jump (0x6f).
- The register-indirect jump (0x67).

The scattered immediate fields of the branch and jump formats are reassembled inside the unit. Every other opcode passes through as plain sequential flow. Register reads, fetch sequencing and trap delivery belong to the surrounding pipeline.

Top module: `rv_flow_redirect`

## Requirements
- R1: For any major opcode other than 0x63, 0x6f and 0x67, redirect is 0, next_pc is pc+4, link_we is 0, and both flags are 0.
- R2: The branch offset has bit 0 zero. Offset bits 4:1 come from instruction bits 11:8, bits 10:5 from 30:25, bit 11 from bit 7 and bit 12 from bit 31. The offset is sign-extended from bit 12. A taken branch gives next_pc = pc + offset.
- R3: Branch funct3 0 is taken when the operands are equal. Funct3 1 is taken when they differ.
- R4: Branch funct3 4 is taken when rs1 < rs2 as signed 64-bit numbers. Funct3 5 is taken when rs1 >= rs2 as signed 64-bit numbers.
- R5: Branch funct3 6 is taken when rs1 < rs2 as unsigned numbers. Funct3 7 is taken when rs1 >= rs2 as unsigned numbers.
- R6: A branch that is not taken gives redirect 0 and next_pc = pc+4, and it raises no misaligned flag whatever its offset.
- R7: A branch with funct3 2 or 3 raises illegal and gives redirect 0 and next_pc = pc+4. The illegal flag is 0 for every other instruction.
- R8: Opcode 0x6f always redirects to pc + offset. The offset has bit 0 zero. Offset bits 10:1 come from instruction bits 30:21, bit 11 from bit 20, bits 19:12 from bits 19:12 and bit 20 from bit 31. The offset is sign-extended from bit 20.
- R9: Opcode 0x67 always redirects to (rs1 + sign-extended instruction bits 31:20) with bit 0 of the sum forced to 0.
- R10: link is pc+4. link_we is 1 exactly for opcodes 0x6f and 0x67.
- R11: The misaligned flag is 1 exactly when a redirect occurs to an address whose bit 1 is 1. The redirect and its target are still produced in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | XLEN | Address of the instruction |
| instr_i | input | 32 | Instruction word |
| rs1_i | input | XLEN | First source operand value |
| rs2_i | input | XLEN | Second source operand value |
| redirect_o | output | 1 | Control flow leaves the sequential path |
| next_pc_o | output | XLEN | Next fetch address |
| link_o | output | XLEN | Return address (pc+4) |
| link_we_o | output | 1 | Return address is to be written to rd |
| misaligned_o | output | 1 | Redirect target is not 4-byte aligned |
| illegal_o | output | 1 | Reserved branch condition code |

## Verification
The unit holds no state. A wrong decode or a bad immediate bit shows at next_pc_o and the flags in the same evaluation as the instruction that causes it. A single misplaced immediate bit moves the target by exactly that bit's weight, so each offset is chosen to light a distinct bit group, including both sign extremes. The comparison tests use operands whose signed and unsigned orderings disagree, so that a swapped compare flips the redirect output.

// File: rtl/rv_flow_redirect.sv
module rv_flow_redirect #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_o,
  output logic            link_we_o,
  output logic            misaligned_o,
  output logic            illegal_o
);
  localparam logic [6:0] OP_BRANCH = 7'h63;
  localparam logic [6:0] OP_JUMP   = 7'h6f;
  localparam logic [6:0] OP_JUMPR  = 7'h67;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [6:0] opc;
  logic [2:0] cond_sel;
  logic is_br, is_jmp, is_jmpr;
  logic [XLEN-1:0] b_off, j_off, i_off;
  logic [XLEN-1:0] seq_pc, rel_tgt, ind_sum, ind_tgt, tgt;
  logic eq, lt_s, lt_u, cond_met, bad_cond, taken;

  assign opc      = instr_i[6:0];
  assign cond_sel = instr_i[14:12];
  assign is_br    = (opc == OP_BRANCH);
  assign is_jmp   = (opc == OP_JUMP);
  assign is_jmpr  = (opc == OP_JUMPR);

  assign b_off = {{(XLEN-13){instr_i[31]}}, instr_i[31], instr_i[7],
                  instr_i[30:25], instr_i[11:8], 1'b0};
  assign j_off = {{(XLEN-21){instr_i[31]}}, instr_i[31], instr_i[19:12],
                  instr_i[20], instr_i[30:21], 1'b0};
  assign i_off = {{(XLEN-12){instr_i[31]}}, instr_i[31:20]};

  assign seq_pc  = pc_i + STEP;
  assign rel_tgt = pc_i + (is_jmp ? j_off : b_off);
  assign ind_sum = rs1_i + i_off;
  assign ind_tgt = {ind_sum[XLEN-1:1], 1'b0};
  assign tgt     = is_jmpr ? ind_tgt : rel_tgt;

  assign eq   = (rs1_i == rs2_i);
  assign lt_s = ($signed(rs1_i) < $signed(rs2_i));
  assign lt_u = (rs1_i < rs2_i);

  always_comb begin
    cond_met = 1'b0;
    bad_cond = 1'b0;
    case (cond_sel)
      3'd0: cond_met = eq;
      3'd1: cond_met = !eq;
      3'd4: cond_met = lt_s;
      3'd5: cond_met = !lt_s;
      3'd6: cond_met = lt_u;
      3'd7: cond_met = !lt_u;
      default: bad_cond = 1'b1;
    endcase
  end

  assign taken        = is_jmp || is_jmpr || (is_br && cond_met);
  assign redirect_o   = taken;
  assign next_pc_o    = taken ? tgt : seq_pc;
  assign link_o       = seq_pc;
  assign link_we_o    = is_jmp || is_jmpr;
  assign misaligned_o = taken && tgt[1];
  assign illegal_o    = is_br && bad_cond;
endmodule

module rv_flow_redirect_chk #(
  parameter int XLEN = 64
) (
  input logic [XLEN-1:0] pc_i,
  input logic [31:0]     instr_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic [XLEN-1:0] link_o,
  input logic            link_we_o,
  input logic            misaligned_o,
  input logic            illegal_o
);
  always_comb begin
    // R7
    illegal_blocks_redirect_chk: assert (!(illegal_o && redirect_o))
      else $error("illegal branch redirected");
    // R6
    sequential_when_idle_chk: assert (redirect_o || next_pc_o == pc_i + XLEN'(4))
      else $error("no redirect but next_pc not sequential");
    // R11
    misaligned_needs_target_chk: assert (!misaligned_o || (redirect_o && next_pc_o[1]))
      else $error("misaligned flag without misaligned redirect");
    // R10
    jump_always_redirects_chk: assert (!link_we_o || redirect_o)
      else $error("link write without redirect");
    // R9
    indirect_bit0_clear_chk: assert (instr_i[6:0] != 7'h67 || !next_pc_o[0])
      else $error("indirect target bit 0 set");
    // R10
    link_is_sequential_chk: assert (link_o == pc_i + XLEN'(4))
      else $error("link value wrong");
  end
endmodule

bind rv_flow_redirect rv_flow_redirect_chk #(.XLEN(XLEN)) u_chk (
  .pc_i(pc_i), .instr_i(instr_i), .redirect_o(redirect_o),
  .next_pc_o(next_pc_o), .link_o(link_o), .link_we_o(link_we_o),
  .misaligned_o(misaligned_o), .illegal_o(illegal_o)
);

// File: tb/rv_flow_redirect_tb.sv
module rv_flow_redirect_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] pc, rs1, rs2, next_pc, link;
  logic [31:0] instr;
  logic redirect, link_we, misal, illegal;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  rv_flow_redirect #(.XLEN(64)) u_dut (
    .pc_i(pc), .instr_i(instr), .rs1_i(rs1), .rs2_i(rs2),
    .redirect_o(redirect), .next_pc_o(next_pc), .link_o(link),
    .link_we_o(link_we), .misaligned_o(misal), .illegal_o(illegal)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] p, input logic [31:0] ins,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    pc = p; instr = ins; rs1 = a; rs2 = b;
    #1;
  endtask

  function automatic logic [31:0] enc_b(input int off, input logic [2:0] f3);
    logic [12:0] i = off[12:0];
    return {i[12], i[10:5], 5'd2, 5'd1, f3, i[4:1], i[11], 7'h63};
  endfunction

  function automatic logic [31:0] enc_j(input int off);
    logic [20:0] i = off[20:0];
    return {i[20], i[10:1], i[11], i[19:12], 5'd1, 7'h6f};
  endfunction

  function automatic logic [31:0] enc_r(input int off);
    logic [11:0] i = off[11:0];
    return {i, 5'd1, 3'd0, 5'd1, 7'h67};
  endfunction

  localparam logic [63:0] PC0 = 64'h8000_0000_0000_1000;

  task automatic t_idle();
    apply(PC0, 32'h0020_8093, 64'd5, 64'd5);
    chk("R1 redirect", {63'd0, redirect}, 64'd0);
    chk("R1 next_pc", next_pc, PC0 + 4);
    chk("R1 link_we", {63'd0, link_we}, 64'd0);
    chk("R1 flags", {62'd0, misal, illegal}, 64'd0);
  endtask

  task automatic t_eq_ne();
    int offs[3] = '{16, -4096, 4094};
    foreach (offs[k]) begin
      apply(PC0, enc_b(offs[k], 3'd0), 64'd7, 64'd7);
      chk("R3 beq taken", {63'd0, redirect}, 64'd1);
      chk("R2 beq target", next_pc, PC0 + 64'(longint'(offs[k])));
      chk("R10 branch no link", {63'd0, link_we}, 64'd0);
      apply(PC0, enc_b(offs[k], 3'd1), 64'd7, 64'd7);
      chk("R3 bne not taken", {63'd0, redirect}, 64'd0);
      chk("R6 bne seq", next_pc, PC0 + 4);
    end
    apply(PC0, enc_b(2048, 3'd1), 64'd1, 64'd2);
    chk("R2 bit11 target", next_pc, PC0 + 64'd2048);
  endtask

  task automatic t_order();
    logic [63:0] neg1 = '1;
    apply(PC0, enc_b(32, 3'd4), neg1, 64'd1);
    chk("R4 blt -1<1", {63'd0, redirect}, 64'd1);
    chk("R4 blt target", next_pc, PC0 + 32);
    apply(PC0, enc_b(32, 3'd5), neg1, 64'd1);
    chk("R4 bge -1>=1", {63'd0, redirect}, 64'd0);
    apply(PC0, enc_b(32, 3'd5), 64'd3, 64'd3);
    chk("R4 bge equal", {63'd0, redirect}, 64'd1);
    apply(PC0, enc_b(32, 3'd6), neg1, 64'd1);
    chk("R5 bltu max<1", {63'd0, redirect}, 64'd0);
    chk("R6 bltu seq", next_pc, PC0 + 4);
    apply(PC0, enc_b(-8, 3'd7), neg1, 64'd1);
    chk("R5 bgeu max>=1", {63'd0, redirect}, 64'd1);
    chk("R5 bgeu target", next_pc, PC0 - 8);
    apply(PC0, enc_b(-8, 3'd6), 64'd1, 64'h8000_0000_0000_0000);
    chk("R5 bltu 1<msb", {63'd0, redirect}, 64'd1);
  endtask

  task automatic t_illegal();
    for (int f = 2; f < 4; f++) begin
      apply(PC0, enc_b(16, 3'(f)), 64'd9, 64'd9);
      chk("R7 illegal flag", {63'd0, illegal}, 64'd1);
      chk("R7 no redirect", {63'd0, redirect}, 64'd0);
      chk("R7 seq pc", next_pc, PC0 + 4);
    end
    apply(PC0, enc_b(16, 3'd0), 64'd9, 64'd9);
    chk("R7 legal clear", {63'd0, illegal}, 64'd0);
  endtask

  task automatic t_jal();
    int offs[4] = '{1048574, -1048576, 2048, 4096};
    foreach (offs[k]) begin
      apply(PC0, enc_j(offs[k]), 64'd0, 64'd0);
      chk("R8 jal redirect", {63'd0, redirect}, 64'd1);
      chk("R8 jal target", next_pc, PC0 + 64'(longint'(offs[k])));
      chk("R10 jal link", link, PC0 + 4);
      chk("R10 jal link_we", {63'd0, link_we}, 64'd1);
    end
  endtask

  task automatic t_jalr();
    apply(PC0, enc_r(-1), 64'h0000_0000_0000_1001, 64'd0);
    chk("R9 jalr target", next_pc, 64'h1000);
    chk("R9 jalr redirect", {63'd0, redirect}, 64'd1);
    chk("R10 jalr link_we", {63'd0, link_we}, 64'd1);
    chk("R11 jalr aligned", {63'd0, misal}, 64'd0);
    apply(PC0, enc_r(2047), 64'h4000, 64'd0);
    chk("R9 jalr max imm", next_pc, 64'h47FE);
    chk("R11 jalr misaligned", {63'd0, misal}, 64'd1);
  endtask

  task automatic t_misal();
    apply(PC0, enc_b(6, 3'd0), 64'd1, 64'd1);
    chk("R11 branch misaligned", {63'd0, misal}, 64'd1);
    chk("R11 branch still redirects", next_pc, PC0 + 6);
    apply(PC0, enc_b(6, 3'd0), 64'd1, 64'd2);
    chk("R6 not taken no flag", {63'd0, misal}, 64'd0);
    apply(PC0, enc_j(-2), 64'd0, 64'd0);
    chk("R11 jal misaligned", {63'd0, misal}, 64'd1);
  endtask

  initial begin
    pc = '0; instr = 32'h13; rs1 = '0; rs2 = '0;
    t_idle();
    t_eq_ne();
    t_order();
    t_illegal();
    t_jal();
    t_jalr();
    t_misal();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule